// File: doc/BRIEF.md
# Serial Management Slave (Clause-22 Frames)

This block is the device side of a two-wire serial management link. A controller toggles a management clock and shifts frames over a single bidirectional data line. The block samples the line on each rising clock edge and checks the frame fields in turn: a run of ones as preamble, then the start pair, the opcode, the device address and the register address. It then either collects sixteen write data bits or returns sixteen read data bits. Its outputs change only after falling clock edges.

Inside the chip the block connects to a plain register port: a register address, write data, a one-cycle write strobe and read data. A strapped device address selects which frames it answers. The block also copes with malformed or foreign frames. It drops them and waits for a new preamble before it accepts another start.

The management clock and data are brought into the system clock domain through a synchroniser. All decoding then runs on single-cycle edge pulses in that domain.

Top module: `mdio_slave`

## Requirements
- R1: After synchronous reset, `mdio_oe` and `reg_we_o` are 0, and `reg_addr_o` and `reg_wdata_o` are all zeros.
- R2: A start is accepted only when the line has carried at least PRE_LEN (default 32) consecutive 1 bits. With only 31 ones before the start, the frame gets no write strobe and the line is never driven.
- R3: The start field must be 0 then 1. The opcode 1,0 (first bit first) means read and 0,1 means write. The opcodes 1,1 and 0,0 cause the frame to be dropped: no strobe and no drive.
- R4: The 5-bit device address field, MSB first, must equal `phy_addr_i`, which can be any value 0..31. A mismatched frame leaves `reg_addr_o`, `reg_wdata_o` and the strobe count unchanged and never drives the line.
- R5: In a write, the 5-bit register address and 16 data bits are taken MSB first. Exactly one one-cycle `reg_we_o` pulse follows the 16th data bit, carrying both values on `reg_addr_o`/`reg_wdata_o`. The block never drives the line during a write.
- R6: In a read, `reg_addr_o` shows the register field and `reg_rdata_i` is captured during the first turnaround bit. That bit is left undriven. The block drives the second turnaround bit as 0, then the captured word MSB first.
- R7: `mdio_oe`/`mdio_o` change only after a falling management clock edge. The line is released in the bit period after the last read data bit.
- R8: After a frame with a bad start field, the next frame with a proper preamble is decoded normally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| mdc_i | input | 1 | Management clock from controller (asynchronous) |
| mdio_i | input | 1 | Resolved level of the management data line |
| mdio_o | output | 1 | Value the block drives onto the data line |
| mdio_oe | output | 1 | Output enable for the data line driver |
| phy_addr_i | input | 5 | Strapped device address |
| reg_addr_o | output | 5 | Register address of the current or last frame |
| reg_wdata_o | output | 16 | Write data, valid with the strobe |
| reg_we_o | output | 1 | One-cycle write strobe |
| reg_rdata_i | input | 16 | Read data for `reg_addr_o` |

## Verification
A management clock edge reaches the decoder after the synchroniser stages plus one edge-detect register. The state, the write strobe and the driver outputs settle one cycle later: four system clocks after the edge with default parameters. The bench holds each management clock level for eight system clocks. It samples the driver outputs at the end of each low phase, which is well past that four-cycle delay. A write strobe lands about four cycles after the last rising edge, and the bench counts strobes on every clock, so the count is read only after the frame's final half period. On every clock the bench also checks that the block and the modelled controller never drive the line together.

// File: rtl/mdio_slave_pkg.sv
package mdio_slave_pkg;
  typedef enum logic [2:0] {
    ST_IDLE, ST_START, ST_OP, ST_PHY, ST_REG, ST_TA, ST_DATA
  } mdio_st_e;

  localparam logic [1:0] OP_READ  = 2'b10;
  localparam logic [1:0] OP_WRITE = 2'b01;
endpackage

// File: rtl/mdio_edge_sync.sv
module mdio_edge_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic mdc_i,
  input  logic mdio_i,
  output logic rise_o,
  output logic fall_o,
  output logic bit_o
);
  localparam int MSB = STAGES - 1;

  logic [STAGES-1:0] mdc_sr;
  logic [STAGES-1:0] dio_sr;
  logic              mdc_prev;

  always_ff @(posedge clk) begin
    if (rst) begin
      mdc_sr   <= '1;
      dio_sr   <= '1;
      mdc_prev <= 1'b1;
      rise_o   <= 1'b0;
      fall_o   <= 1'b0;
      bit_o    <= 1'b1;
    end else begin
      mdc_sr   <= {mdc_sr[STAGES-2:0], mdc_i};
      dio_sr   <= {dio_sr[STAGES-2:0], mdio_i};
      mdc_prev <= mdc_sr[MSB];
      rise_o   <= mdc_sr[MSB] & ~mdc_prev;
      fall_o   <= ~mdc_sr[MSB] & mdc_prev;
      bit_o    <= dio_sr[MSB];
    end
  end

  AST_EDGE_EXCL: assert property (@(posedge clk) disable iff (rst)
    rise_o |=> !rise_o) else $error("rise pulse longer than one cycle"); // R7
endmodule

// File: rtl/mdio_frame_rx.sv
module mdio_frame_rx
  import mdio_slave_pkg::*;
#(
  parameter int PRE_LEN = 32,
  parameter int ADDR_W  = 5,
  parameter int DATA_W  = 16,
  parameter int CNT_W   = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rise_i,
  input  logic              bit_i,
  input  logic [ADDR_W-1:0] phy_addr_i,
  output mdio_st_e          st_o,
  output logic [CNT_W-1:0]  cnt_o,
  output logic              is_rd_o,
  output logic [ADDR_W-1:0] reg_addr_o,
  output logic [DATA_W-1:0] wdata_o,
  output logic              we_o
);
  localparam int               PC_W      = $clog2(PRE_LEN + 1);
  localparam logic [PC_W-1:0]  PC_MAX    = PC_W'(PRE_LEN);
  localparam logic [CNT_W-1:0] ADDR_LAST = CNT_W'(ADDR_W - 1);
  localparam logic [CNT_W-1:0] DATA_LAST = CNT_W'(DATA_W - 1);

  mdio_st_e          st_q;
  logic [CNT_W-1:0]  cnt_q;
  logic [PC_W-1:0]   ones_q;
  logic [DATA_W-1:0] sh_q;
  logic [DATA_W-1:0] shn;
  logic              is_rd_q;

  assign shn     = {sh_q[DATA_W-2:0], bit_i};
  assign st_o    = st_q;
  assign cnt_o   = cnt_q;
  assign is_rd_o = is_rd_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q       <= ST_IDLE;
      cnt_q      <= '0;
      ones_q     <= '0;
      sh_q       <= '0;
      is_rd_q    <= 1'b0;
      reg_addr_o <= '0;
      wdata_o    <= '0;
      we_o       <= 1'b0;
    end else begin
      we_o <= 1'b0;
      if (rise_i) begin
        sh_q   <= shn;
        ones_q <= bit_i ? ((ones_q == PC_MAX) ? ones_q : ones_q + 1'b1) : '0;
        case (st_q)
          ST_IDLE: if (!bit_i && ones_q >= PC_MAX) st_q <= ST_START;
          ST_START: begin
            cnt_q <= '0;
            st_q  <= bit_i ? ST_OP : ST_IDLE;
          end
          ST_OP: begin
            if (cnt_q == '0) begin
              cnt_q <= cnt_q + 1'b1;
            end else begin
              cnt_q <= '0;
              if (shn[1:0] == OP_READ) begin
                is_rd_q <= 1'b1;
                st_q    <= ST_PHY;
              end else if (shn[1:0] == OP_WRITE) begin
                is_rd_q <= 1'b0;
                st_q    <= ST_PHY;
              end else begin
                st_q <= ST_IDLE;
              end
            end
          end
          ST_PHY: begin
            if (cnt_q != ADDR_LAST) begin
              cnt_q <= cnt_q + 1'b1;
            end else begin
              cnt_q <= '0;
              st_q  <= (shn[ADDR_W-1:0] == phy_addr_i) ? ST_REG : ST_IDLE;
            end
          end
          ST_REG: begin
            if (cnt_q != ADDR_LAST) begin
              cnt_q <= cnt_q + 1'b1;
            end else begin
              cnt_q      <= '0;
              reg_addr_o <= shn[ADDR_W-1:0];
              st_q       <= ST_TA;
            end
          end
          ST_TA: begin
            if (cnt_q == '0) begin
              cnt_q <= cnt_q + 1'b1;
            end else begin
              cnt_q <= '0;
              st_q  <= ST_DATA;
            end
          end
          ST_DATA: begin
            if (cnt_q != DATA_LAST) begin
              cnt_q <= cnt_q + 1'b1;
            end else begin
              cnt_q <= '0;
              st_q  <= ST_IDLE;
              if (!is_rd_q) begin
                wdata_o <= shn;
                we_o    <= 1'b1;
              end
            end
          end
          default: st_q <= ST_IDLE;
        endcase
      end
    end
  end

  AST_SHORT_PREAMBLE: assert property (@(posedge clk) disable iff (rst)
    (rise_i && st_q == ST_IDLE && !bit_i && ones_q < PC_MAX) |=> st_q == ST_IDLE)
    else $error("start accepted after short preamble"); // R2
  AST_BAD_OPCODE: assert property (@(posedge clk) disable iff (rst)
    (rise_i && st_q == ST_OP && cnt_q != '0 && sh_q[0] == bit_i) |=> st_q == ST_IDLE)
    else $error("unknown opcode not dropped"); // R3
  AST_ADDR_MISS: assert property (@(posedge clk) disable iff (rst)
    (st_q == ST_REG) |-> $past(st_q) != ST_IDLE)
    else $error("register field entered without address phase"); // R4
  AST_WE_PULSE: assert property (@(posedge clk) disable iff (rst)
    we_o |=> !we_o) else $error("write strobe wider than one cycle"); // R5
  AST_WE_WRITE_ONLY: assert property (@(posedge clk) disable iff (rst)
    we_o |-> (!is_rd_q && st_q == ST_IDLE)) else $error("strobe outside write frame"); // R5
endmodule

// File: rtl/mdio_tx_drv.sv
module mdio_tx_drv
  import mdio_slave_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int CNT_W  = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rise_i,
  input  logic              fall_i,
  input  mdio_st_e          st_i,
  input  logic [CNT_W-1:0]  cnt_i,
  input  logic              is_rd_i,
  input  logic [DATA_W-1:0] rdata_i,
  output logic              oe_o,
  output logic              out_o
);
  localparam logic [CNT_W-1:0] DATA_LAST = CNT_W'(DATA_W - 1);

  logic [DATA_W-1:0] buf_q;
  logic [CNT_W-1:0]  idx;

  assign idx = DATA_LAST - cnt_i;

  always_ff @(posedge clk) begin
    if (rst) begin
      buf_q <= '0;
      oe_o  <= 1'b0;
      out_o <= 1'b1;
    end else begin
      if (rise_i && is_rd_i && st_i == ST_TA && cnt_i == '0) buf_q <= rdata_i;
      if (fall_i) begin
        if (is_rd_i && st_i == ST_TA && cnt_i != '0) begin
          oe_o  <= 1'b1;
          out_o <= 1'b0;
        end else if (is_rd_i && st_i == ST_DATA) begin
          oe_o  <= 1'b1;
          out_o <= buf_q[idx];
        end else begin
          oe_o  <= 1'b0;
          out_o <= 1'b1;
        end
      end
    end
  end

  AST_OE_ON_FALL: assert property (@(posedge clk) disable iff (rst)
    (oe_o != $past(oe_o)) |-> $past(fall_i)) else $error("enable moved off a falling edge"); // R7
  AST_OUT_ON_FALL: assert property (@(posedge clk) disable iff (rst)
    (out_o != $past(out_o)) |-> $past(fall_i)) else $error("data moved off a falling edge"); // R7
endmodule

// File: rtl/mdio_slave.sv
module mdio_slave
  import mdio_slave_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int PRE_LEN     = 32,
  parameter int ADDR_W      = 5,
  parameter int DATA_W      = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              mdc_i,
  input  logic              mdio_i,
  output logic              mdio_o,
  output logic              mdio_oe,
  input  logic [ADDR_W-1:0] phy_addr_i,
  output logic [ADDR_W-1:0] reg_addr_o,
  output logic [DATA_W-1:0] reg_wdata_o,
  output logic              reg_we_o,
  input  logic [DATA_W-1:0] reg_rdata_i
);
  localparam int CNT_W = $clog2(DATA_W);

  logic             rise, fall, sbit, is_rd;
  mdio_st_e         st;
  logic [CNT_W-1:0] cnt;

  mdio_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .mdc_i(mdc_i), .mdio_i(mdio_i),
    .rise_o(rise), .fall_o(fall), .bit_o(sbit)
  );

  mdio_frame_rx #(.PRE_LEN(PRE_LEN), .ADDR_W(ADDR_W), .DATA_W(DATA_W), .CNT_W(CNT_W)) u_rx (
    .clk(clk), .rst(rst), .rise_i(rise), .bit_i(sbit), .phy_addr_i(phy_addr_i),
    .st_o(st), .cnt_o(cnt), .is_rd_o(is_rd), .reg_addr_o(reg_addr_o),
    .wdata_o(reg_wdata_o), .we_o(reg_we_o)
  );

  mdio_tx_drv #(.DATA_W(DATA_W), .CNT_W(CNT_W)) u_tx (
    .clk(clk), .rst(rst), .rise_i(rise), .fall_i(fall), .st_i(st), .cnt_i(cnt),
    .is_rd_i(is_rd), .rdata_i(reg_rdata_i), .oe_o(mdio_oe), .out_o(mdio_o)
  );

  AST_NO_DRIVE_WRITE: assert property (@(posedge clk) disable iff (rst)
    mdio_oe |-> is_rd) else $error("line driven outside a read"); // R5
  AST_DRIVE_IN_FRAME: assert property (@(posedge clk) disable iff (rst)
    (mdio_oe && !$past(mdio_oe)) |-> (st == ST_TA || st == ST_DATA))
    else $error("drive started outside turnaround"); // R6
endmodule

// File: tb/tb_mdio_slave.sv
module tb_mdio_slave;
  localparam int CLK_PERIOD = 10;
  localparam int HALF       = 8;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        mdc = 1'b1;
  logic        ctrl_oe = 1'b0;
  logic        ctrl_bit = 1'b1;
  logic [4:0]  phy_addr = 5'h13;
  logic        mdio_o, mdio_oe, reg_we;
  logic [4:0]  reg_addr;
  logic [15:0] reg_wdata, reg_rdata;
  logic        line;

  int tests = 0, fails = 0, we_cnt = 0;
  logic [4:0]  we_addr_q[$];
  logic [15:0] we_data_q[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [15:0] rd_model(input logic [4:0] r);
    return 16'hC0DE ^ {r, r, r, 1'b0};
  endfunction

  assign line      = mdio_oe ? mdio_o : (ctrl_oe ? ctrl_bit : 1'b1);
  assign reg_rdata = rd_model(reg_addr);

  mdio_slave dut (
    .clk(clk), .rst(rst), .mdc_i(mdc), .mdio_i(line), .mdio_o(mdio_o),
    .mdio_oe(mdio_oe), .phy_addr_i(phy_addr), .reg_addr_o(reg_addr),
    .reg_wdata_o(reg_wdata), .reg_we_o(reg_we), .reg_rdata_i(reg_rdata)
  );

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  // every-clock monitor: strobe log and bus contention (R5, R6)
  always @(negedge clk) begin
    if (!rst) begin
      if (reg_we) begin
        we_cnt++;
        we_addr_q.push_back(reg_addr);
        we_data_q.push_back(reg_wdata);
      end
      if (mdio_oe && ctrl_oe) chk(1'b0, "R5 contention", 1, 0);
    end
  end

  task automatic bit_period(input logic drv, input logic val, output logic s_oe, output logic s_o);
    @(negedge clk);
    mdc = 1'b0; ctrl_oe = drv; ctrl_bit = val;
    repeat (HALF - 1) @(negedge clk);
    s_oe = mdio_oe; s_o = mdio_o;
    @(negedge clk);
    mdc = 1'b1;
    repeat (HALF - 1) @(negedge clk);
  endtask

  task automatic send(input logic val);
    logic a, b;
    bit_period(1'b1, val, a, b);
  endtask

  task automatic frame(input int pre, input logic [1:0] stf, input logic [1:0] op,
                       input logic [4:0] phy, input logic [4:0] ra, input logic [15:0] wd,
                       input bit respond, input string tag);
    logic so, sv;
    int   cnt0;
    bit   drove;
    logic [15:0] exp;
    cnt0 = we_cnt;
    drove = 0;
    for (int i = 0; i < pre; i++) begin
      bit_period(1'b1, 1'b1, so, sv);
      if (so) drove = 1;
    end
    for (int i = 1; i >= 0; i--) begin bit_period(1'b1, stf[i], so, sv); if (so) drove = 1; end
    for (int i = 1; i >= 0; i--) begin bit_period(1'b1, op[i], so, sv); if (so) drove = 1; end
    for (int i = 4; i >= 0; i--) begin bit_period(1'b1, phy[i], so, sv); if (so) drove = 1; end
    for (int i = 4; i >= 0; i--) begin bit_period(1'b1, ra[i], so, sv); if (so) drove = 1; end
    if (op != 2'b10) begin
      bit_period(1'b1, 1'b1, so, sv); if (so) drove = 1;
      bit_period(1'b1, 1'b0, so, sv); if (so) drove = 1;
      for (int i = 15; i >= 0; i--) begin bit_period(1'b1, wd[i], so, sv); if (so) drove = 1; end
      bit_period(1'b0, 1'b1, so, sv); if (so) drove = 1;
      chk(!drove, {tag, " no drive"}, drove, 0);
      if (respond) begin
        chk(we_cnt == cnt0 + 1, {tag, " one strobe"}, we_cnt - cnt0, 1);
        if (we_addr_q.size() > 0) begin
          chk(we_addr_q[$] == ra, {tag, " strobe addr"}, we_addr_q[$], ra);
          chk(we_data_q[$] == wd, {tag, " strobe data"}, we_data_q[$], wd);
        end
      end else begin
        chk(we_cnt == cnt0, {tag, " no strobe"}, we_cnt - cnt0, 0);
      end
    end else begin
      exp = rd_model(ra);
      chk(!drove, {tag, " header undriven"}, drove, 0);
      bit_period(1'b0, 1'b1, so, sv);
      chk(so == 1'b0, {tag, " TA1 undriven"}, so, 0);
      bit_period(1'b0, 1'b1, so, sv);
      if (respond) chk(so && !sv, {tag, " TA2 zero"}, {so, sv}, 2'b10);
      else         chk(!so, {tag, " TA2 undriven"}, so, 0);
      for (int i = 15; i >= 0; i--) begin
        bit_period(1'b0, 1'b1, so, sv);
        if (respond) chk(so && sv == exp[i], {tag, " data bit"}, {so, sv, 8'(i)}, {1'b1, exp[i], 8'(i)});
        else         chk(!so, {tag, " data undriven"}, so, 0);
      end
      bit_period(1'b0, 1'b1, so, sv);
      chk(!so, {tag, " R7 released"}, so, 0);
      chk(we_cnt == cnt0, {tag, " read no strobe"}, we_cnt - cnt0, 0);
      if (respond) chk(reg_addr == ra, {tag, " reg addr"}, reg_addr, ra);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    logic [4:0]  a_keep;
    logic [15:0] d_keep;
    repeat (5) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(!mdio_oe && !reg_we, "R1 reset outputs", {mdio_oe, reg_we}, 0);
    chk(reg_addr == 0 && reg_wdata == 0, "R1 reset regs", {reg_addr, reg_wdata}, 0);

    frame(32, 2'b01, 2'b01, 5'h13, 5'h04, 16'hBEEF, 1, "R5 write");
    frame(32, 2'b01, 2'b10, 5'h13, 5'h04, 16'h0000, 1, "R6 read");
    frame(40, 2'b01, 2'b10, 5'h13, 5'h1A, 16'h0000, 1, "R6 read long pre");

    a_keep = reg_addr; d_keep = reg_wdata;
    frame(32, 2'b01, 2'b01, 5'h12, 5'h07, 16'h1234, 0, "R4 write miss");
    chk(reg_wdata == d_keep, "R4 wdata kept", reg_wdata, d_keep);
    frame(32, 2'b01, 2'b10, 5'h03, 5'h09, 16'h0000, 0, "R4 read miss");
    chk(reg_addr == a_keep, "R4 addr kept", reg_addr, a_keep);

    frame(32, 2'b01, 2'b11, 5'h13, 5'h05, 16'h5555, 0, "R3 op 11");
    frame(32, 2'b01, 2'b00, 5'h13, 5'h05, 16'hAAAA, 0, "R3 op 00");

    send(1'b0);
    frame(31, 2'b01, 2'b01, 5'h13, 5'h06, 16'h7777, 0, "R2 short pre");
    frame(32, 2'b01, 2'b01, 5'h13, 5'h06, 16'h7777, 1, "R2 exact pre");

    frame(32, 2'b00, 2'b01, 5'h13, 5'h08, 16'h9999, 0, "R8 bad start");
    frame(32, 2'b01, 2'b01, 5'h13, 5'h08, 16'h0F0F, 1, "R8 resync write");

    phy_addr = 5'h00;
    frame(32, 2'b01, 2'b01, 5'h00, 5'h1F, 16'hFFFF, 1, "R4 addr 0 write");
    phy_addr = 5'h1F;
    frame(32, 2'b01, 2'b10, 5'h1F, 5'h00, 16'h0000, 1, "R4 addr 31 read");
    frame(32, 2'b01, 2'b01, 5'h1F, 5'h00, 16'h0001, 1, "R5 write lsb");

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule